// File: doc/BRIEF.md
# Bit-Stepped Serial EEPROM Slave (Read-Only)

This block models the target side of a two-wire serial EEPROM that holds 256 bytes and cannot be written. It does not oversample the bus. A host logic block, typically a register that software toggles bit by bit, presents the clock line level on `scl_in` and the data line level on `sda_in`. It raises `step` for one clock whenever those levels have been updated. On each step the block compares the new levels with those of the previous step. From that comparison it finds start and stop conditions, clock rising edges carrying a data bit, and illegal data changes.

A frame starts with a START. Then comes a command byte whose least significant bit picks read (1) or write (0), followed by an acknowledge. In write mode the next byte is a memory address. Once it has arrived, the byte at that address is fetched from the table into a data register and a second acknowledge follows. A STOP, or a fresh START, then a read command, shifts that data byte out most significant bit first. The data line driven by the slave is a single logic level, `sda_out`, where 1 means released.

Top module: `serial_rom_slave`

## Requirements
- R1: During and right after reset, `sda_out` is 1 and `proto_err` is 0.
- R2: Until a START has been seen, clock edges and data changes have no effect: `sda_out` stays 1 and `proto_err` stays 0.
- R3: With the clock line high on both the previous and the current step, a falling data line is a START and a rising data line is a STOP. Either one restarts the bit count from zero. A STOP also sets `sda_out` to 1 and drops any pending acknowledge.
- R4: After a START, the first 8 accepted bits form the command, most significant bit first. On the 8th bit `sda_out` goes to 0 (acknowledge), and bit 0 of that byte selects read when 1.
- R5: The rising clock edge that follows an acknowledge is consumed without counting a bit. After it, `sda_out` is 1 in write mode, or the data register's bit 7 in read mode.
- R6: In write mode the next 8 bits form the address, most significant bit first. On the 8th of them the data register is loaded from the table at that address, `sda_out` goes to 0, and after the acknowledge edge `sda_out` shows bit 7 of the loaded byte.
- R7: In read mode each of the 8 bit edges after the command acknowledge moves `sda_out` to the next lower bit of the data register. After the 8th edge the register is reloaded from the table at the held address and an acknowledge (0) is driven.
- R8: The table is filled at reset with byte value (a*ROM_MUL + ROM_ADD) mod 256 at address a, which is (a*29 + 91) mod 256 with default parameters.
- R9: Past the second acknowledge, every further bit edge keeps presenting the same byte, bit 7 down to bit 0 and then from bit 7 again. The address does not advance.
- R10: A rising clock edge on which the data line also changes raises `proto_err` for exactly one clock and is not counted as a bit.
- R11: While `step` is 0, line changes are not sampled: `sda_out` holds and `proto_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Line levels were updated; sample them this clock |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level from the bus master |
| sda_out | output | 1 | Data level driven by this slave (1 = released) |
| proto_err | output | 1 | One-clock pulse on a data change during a clock rise |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 8-bit data and the table formula (a*29 + 91) mod 256. This makes every one of the 256 table bytes addressable. Random write-address-then-read transactions, together with the directed addresses 0x00 and 0xFF, read back whole bytes and check them against the formula. The same frames also check the wrap-around repetition past the second acknowledge. Directed frames cover a STOP in the middle of a command, an illegal data change during a clock rise, line activity before any START, and line changes while `step` is low.

// File: rtl/serial_rom_pkg.sv
// Package: shared types for the bit-stepped serial ROM slave.
// Assumes: one line event is classified per sampled step.
package serial_rom_pkg;

    // Classification of one sampled step of the two bus lines.
    typedef enum logic [2:0] {
        LN_NONE  = 3'd0,  // nothing of interest
        LN_START = 3'd1,  // data falls while clock stays high
        LN_STOP  = 3'd2,  // data rises while clock stays high
        LN_RISE  = 3'd3,  // clock rises, data steady: a bit
        LN_BAD   = 3'd4   // clock rises and data changes: violation
    } line_evt_e;

endpackage

// File: rtl/line_event_detector.sv
// Module: line_event_detector
// Keeps the line levels seen at the previous step and classifies the
// current levels against them. Assumes inputs are meaningful only when
// step is high; the previous levels reset to the idle bus (both high).
module line_event_detector
    import serial_rom_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    input  logic      scl_in,
    input  logic      sda_in,
    output line_evt_e evt
);

    logic prev_scl;
    logic prev_sda;

    // Remember line levels of the last sampled step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_scl <= 1'b1;
            prev_sda <= 1'b1;
        end else if (step) begin
            prev_scl <= scl_in;
            prev_sda <= sda_in;
        end
    end

    // Classify the current levels against the remembered ones.
    always_comb begin
        evt = LN_NONE;
        if (prev_scl && scl_in && (prev_sda != sda_in)) begin
            evt = sda_in ? LN_STOP : LN_START;
        end else if (!prev_scl && scl_in) begin
            evt = (prev_sda != sda_in) ? LN_BAD : LN_RISE;
        end
    end

endmodule

// File: rtl/rom_table.sv
// Module: rom_table
// Read-only byte table, filled at reset from an arithmetic formula
// (a*ROM_MUL + ROM_ADD, truncated) and read combinationally.
// Assumes nothing writes it after reset.
module rom_table #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int ROM_MUL = 29,
    parameter int ROM_ADD = 91
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Load the table contents during reset; hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= DATA_W'(i * ROM_MUL + ROM_ADD);
            end
        end
    end

    // Asynchronous read port.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/serial_rom_slave.sv
// Module: serial_rom_slave
// Bit-stepped two-wire EEPROM target, read-only. Counts accepted bits
// from each START: command byte, acknowledge, then address (write) or
// data out (read), second acknowledge, then endless data repetition.
// Assumes the master updates lines one level change per step.
module serial_rom_slave
    import serial_rom_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int ROM_MUL = 29,
    parameter int ROM_ADD = 91
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out,
    output logic proto_err
);

    localparam int CMD_BITS = 8;
    localparam int PH2_END  = CMD_BITS + ADDR_W;
    localparam int TICK_W   = $clog2(PH2_END + 1);

    line_evt_e         evt;
    logic              active;
    logic              ack_pend;
    logic              is_read;
    logic [TICK_W-1:0] tick;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] next_addr;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rom_byte;

    line_event_detector u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    // Address as it will stand after the current bit (write mode shifts).
    assign next_addr = is_read ? addr_q : {addr_q[ADDR_W-2:0], sda_in};

    rom_table #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ROM_MUL (ROM_MUL),
        .ROM_ADD (ROM_ADD)
    ) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (next_addr),
        .rd_data (rom_byte)
    );

    // Frame sequencer: bit counting, shifting, acknowledge and output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            ack_pend  <= 1'b0;
            is_read   <= 1'b0;
            tick      <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            sda_out   <= 1'b1;
            proto_err <= 1'b0;
        end else begin
            proto_err <= 1'b0;
            if (step) begin
                case (evt)
                    LN_START: begin
                        active   <= 1'b1;
                        tick     <= '0;
                        ack_pend <= 1'b0;
                        sda_out  <= 1'b1;
                    end
                    LN_STOP: begin
                        active   <= 1'b0;
                        tick     <= '0;
                        ack_pend <= 1'b0;
                        sda_out  <= 1'b1;
                    end
                    LN_BAD: begin
                        if (active) begin
                            proto_err <= 1'b1;
                        end
                    end
                    LN_RISE: begin
                        if (active) begin
                            if (ack_pend) begin
                                ack_pend <= 1'b0;
                                sda_out  <= (is_read || tick == TICK_W'(PH2_END))
                                            ? data_q[DATA_W-1] : 1'b1;
                            end else if (tick < TICK_W'(CMD_BITS)) begin
                                tick <= tick + TICK_W'(1);
                                if (tick == TICK_W'(CMD_BITS - 1)) begin
                                    is_read  <= sda_in;
                                    ack_pend <= 1'b1;
                                    sda_out  <= 1'b0;
                                end
                            end else if (tick < TICK_W'(PH2_END)) begin
                                tick <= tick + TICK_W'(1);
                                if (is_read) begin
                                    data_q  <= {data_q[DATA_W-2:0], data_q[DATA_W-1]};
                                    sda_out <= data_q[DATA_W-2];
                                end else begin
                                    addr_q  <= next_addr;
                                end
                                if (tick == TICK_W'(PH2_END - 1)) begin
                                    data_q   <= rom_byte;
                                    ack_pend <= 1'b1;
                                    sda_out  <= 1'b0;
                                end
                            end else begin
                                data_q  <= {data_q[DATA_W-2:0], data_q[DATA_W-1]};
                                sda_out <= data_q[DATA_W-2];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: no sampling without step.
    a_r11_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(sda_out) && !proto_err));

    // R10: a violation flag lasts exactly one clock.
    a_r10_err_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> !proto_err);

    // R3: a STOP releases the data line.
    a_r3_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (step && evt == LN_STOP) |=> sda_out);

    // R4: a pending acknowledge always holds the data line low.
    a_r4_ack_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pend |-> !sda_out);

    // R2: outside a frame the data line is released.
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> sda_out);

    // R9: bit count never passes the end of the second byte.
    a_r9_tick_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tick <= TICK_W'(PH2_END));

endmodule

// File: tb/tb_serial_rom_slave.sv
module tb_serial_rom_slave;

    logic clk = 1'b0;
    logic rst_n;
    logic step;
    logic scl_in;
    logic sda_in;
    logic sda_out;
    logic proto_err;

    int n_vec = 0;
    int n_bad = 0;
    logic cs = 1'b1;
    logic cd = 1'b1;

    always #2 clk = ~clk;

    serial_rom_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_out   (sda_out),
        .proto_err (proto_err)
    );

    function automatic logic [7:0] rom_exp(input int a);
        return 8'((a * 29 + 91) & 255);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic s, input logic d);
        @(negedge clk);
        scl_in = s; sda_in = d; step = 1'b1;
        cs = s; cd = d;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        drive(1'b0, b);
        drive(1'b1, b);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic ack_edge();
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
    endtask

    task automatic do_start();   // clock must be high
        if (!cd) drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
    endtask

    task automatic do_stop();    // clock must be high
        if (cd) drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
    endtask

    task automatic read_at(input logic [7:0] a);
        logic [7:0] e;
        logic [7:0] got;
        e = rom_exp(int'(a));
        do_start();
        send_byte(8'hA0);
        chk("R4 write cmd ack", {7'd0, sda_out}, 8'd0);
        ack_edge();
        chk("R5 write mode release", {7'd0, sda_out}, 8'd1);
        send_byte(a);
        chk("R6 address ack", {7'd0, sda_out}, 8'd0);
        ack_edge();
        chk("R6 loaded msb", {7'd0, sda_out}, {7'd0, e[7]});
        do_stop();
        chk("R3 stop release", {7'd0, sda_out}, 8'd1);
        do_start();
        send_byte(8'hA1);
        chk("R4 read cmd ack", {7'd0, sda_out}, 8'd0);
        ack_edge();
        got = '0;
        got[7] = sda_out;
        for (int k = 1; k < 8; k++) begin
            send_bit(1'b1);
            got[7-k] = sda_out;
        end
        chk("R7 R8 byte read", got, e);
        send_bit(1'b1);
        chk("R7 second ack", {7'd0, sda_out}, 8'd0);
        ack_edge();
        got = '0;
        got[7] = sda_out;
        for (int k = 1; k < 8; k++) begin
            send_bit(1'b1);
            got[7-k] = sda_out;
        end
        chk("R9 repeated byte", got, e);
        send_bit(1'b1);
        chk("R9 wraps to msb", {7'd0, sda_out}, {7'd0, e[7]});
        do_stop();
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] cmd;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; step = 1'b0; scl_in = 1'b1; sda_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset sda_out", {7'd0, sda_out}, 8'd1);
        chk("R1 reset proto_err", {7'd0, proto_err}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {6'd0, proto_err, sda_out}, 8'd1);

        // R2: activity before any START
        for (int i = 0; i < 10; i++) send_bit(1'(i & 1));
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b1);
        chk("R2 idle ignores", {6'd0, proto_err, sda_out}, 8'd1);
        drive(1'b1, 1'b1);

        // R3: STOP in mid-command restarts the count
        do_start();
        send_byte(8'hF0);   // all 8 bits: ack expected, then abort
        do_stop();
        do_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        do_stop();
        do_start();
        cmd = 8'h5A;
        for (int i = 7; i >= 1; i--) send_bit(cmd[i]);
        chk("R3 count restarted", {7'd0, sda_out}, 8'd1);
        send_bit(cmd[0]);
        chk("R3 R4 ack on eighth", {7'd0, sda_out}, 8'd0);
        do_stop();

        // R10: violation during a clock rise
        do_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b1);
        chk("R10 violation flagged", {7'd0, proto_err}, 8'd1);
        drive(1'b1, 1'b1);
        chk("R10 single pulse", {7'd0, proto_err}, 8'd0);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        chk("R10 bit not counted", {7'd0, sda_out}, 8'd1);
        send_bit(1'b0);
        chk("R10 ack after eight good", {7'd0, sda_out}, 8'd0);
        do_stop();

        // R11: line changes without step
        do_start();
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            scl_in = 1'(i & 1);
            sda_in = 1'((i >> 1) & 1);
        end
        @(negedge clk);
        chk("R11 held without step", {6'd0, proto_err, sda_out}, 8'd1);
        scl_in = cs; sda_in = cd;
        send_bit(1'b1);
        chk("R11 ack on stepped eighth", {7'd0, sda_out}, 8'd0);
        do_stop();

        // Directed corner addresses and constrained random ones
        read_at(8'h00);
        read_at(8'hFF);
        for (int n = 0; n < 40; n++) read_at(8'($urandom_range(0, 255)));

        summary();
        $finish;
    end

endmodule